// File: doc/BRIEF.md
# Serial Frame Address Extractor

This block sits beside an Ethernet MAC that exposes its received bit stream as NRZ data plus a receive clock. All of its logic runs on the faster system clock: the serial clock and data are oversampled through a synchronizer, and a rising edge of the synchronized serial clock marks each bit. A monitor counts serial clock edges before it declares the clock usable. It also times how long the serial clock stays low, which is how the block detects loss of carrier.

Once the clock is qualified and the MAC reports itself ready, the parser hunts through the preamble for the start-of-frame delimiter. It then packs the destination address and the source address into 16-bit segments, three per address. Each segment goes to a downstream CAM lookup sequencer as a one-cycle strobe with a tag. The tag says which address the segment belongs to and gives its position. When carrier disappears in the middle of the addresses, the block raises an error pulse and returns to the search. When the MAC withdraws its ready signal, the block signals an abort, waits until the lookup sequencer is idle, and then parks.

Top module: `ser_addr_extract`

## Requirements
- R1: While the synchronous active-low reset is held for at least two cycles, and on the first cycle after it is released, `seg_vld`, `frame_err`, `abort_o` and `clk_ok` are all 0.
- R2: `clk_ok` rises only after four rising edges of the serial clock, with no low stretch of more than 16 system cycles between them. Bits that arrive before the parser is armed are never matched against the delimiter.
- R3: The delimiter is the pattern 1,0,1,0,1,0,1,1 in arrival order. Any preamble of alternating bits at least two bytes long in front of it is accepted.
- R4: After the delimiter, exactly six segments are strobed, each `seg_vld` lasting one cycle. The first three have `seg_src`=0 (destination) with `seg_idx` 0, 1, 2. The next three have `seg_src`=1 (source) with `seg_idx` 0, 1, 2.
- R5: Each byte is received least significant bit first. The first byte of a segment lands in `seg_data[15:8]` and the second in `seg_data[7:0]`. This makes the segments the address in big-endian order, with the first transmitted byte most significant.
- R6: Once the sixth segment has been strobed, no delimiter search takes place until the frame ends. A delimiter pattern in the payload produces no segment.
- R7: If the serial clock stays low for more than 16 system cycles while address bits are being collected, `frame_err` pulses for exactly one cycle and `clk_ok` drops.
- R8: Loss of carrier after all six segments have been strobed, or before a delimiter has been found, raises no `frame_err`.
- R9: While `net_rdy_n` is high, no frame is parsed and no segment is strobed.
- R10: If `net_rdy_n` goes high in the middle of a frame, `abort_o` stays high for as long as `lkp_busy` is high, and no further segment is strobed. After `lkp_busy` goes low, `abort_o` falls and the parser is idle.
- R11: A reset in the middle of a frame discards any partly assembled segment. The next frame yields exactly its own six correct segments.
- R12: After a loss-of-carrier error, the next frame is parsed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, master clock of all logic |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Receive clock from the MAC (asynchronous) |
| ser_dat | input | 1 | NRZ receive data, valid on rising ser_clk |
| net_rdy_n | input | 1 | Active-low: MAC ready to deliver frames |
| lkp_busy | input | 1 | Downstream lookup sequencer still has work in flight |
| seg_vld | output | 1 | One-cycle strobe: a segment is on seg_data |
| seg_data | output | 16 | Address segment, big-endian |
| seg_src | output | 1 | 0 = destination segment, 1 = source segment |
| seg_idx | output | 2 | Segment position within its address, 0 to 2 |
| frame_err | output | 1 | One-cycle pulse: carrier lost during the addresses |
| abort_o | output | 1 | Abort in progress; discard the in-flight lookup result |
| clk_ok | output | 1 | Serial clock has been qualified as toggling |

## Verification
The hardest state to reach is the abort drain. It needs ready to be withdrawn after some segments have already gone out, while the lookup sequencer still reports busy, and with the serial clock kept running so that a loss-of-carrier path does not mask the drain. The bench holds `lkp_busy` high from before the delimiter, raises `net_rdy_n` just after the second segment, and keeps sending address bits. It then checks that `abort_o` is held and that no segment appears. Only after that does it drop `lkp_busy` and confirm that `abort_o` clears. A second hard case is a delimiter pattern buried in the addresses and in the payload. The stimulus table places 0xD5 bytes in both to show that no re-synchronisation occurs.

// File: rtl/sal_pkg.sv
package sal_pkg;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_HUNT,
        PS_ADDR,
        PS_DONE,
        PS_DRAIN
    } pstate_e;

    // delimiter as seen in the hunt window, oldest bit in the MSB
    localparam logic [7:0] SFD_WINDOW = 8'b1010_1011;

endpackage

// File: rtl/sal_sync.sv
module sal_sync #(
    parameter int             STAGES  = 2,
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/sal_clk_mon.sv
module sal_clk_mon #(
    parameter int LOC_LIMIT  = 16,
    parameter int QUAL_EDGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    output logic rise_o,
    output logic loss_o,
    output logic ok_o
);

    localparam int LOW_W  = $clog2(LOC_LIMIT + 2);
    localparam int EDGE_W = $clog2(QUAL_EDGES + 1);
    localparam logic [LOW_W-1:0]  LOW_TRIP = LOW_W'(LOC_LIMIT);
    localparam logic [LOW_W-1:0]  LOW_SAT  = LOW_W'(LOC_LIMIT + 1);
    localparam logic [EDGE_W-1:0] EDGE_MAX = EDGE_W'(QUAL_EDGES);

    typedef struct packed {
        logic              prev;
        logic [LOW_W-1:0]  low_cnt;
        logic [EDGE_W-1:0] edges;
        logic              ok;
        logic              loss;
    } mon_t;

    mon_t m_d, m_q;
    logic rise;

    assign rise = sclk_s & ~m_q.prev;

    always_comb begin
        m_d      = m_q;
        m_d.prev = sclk_s;
        m_d.loss = 1'b0;
        if (sclk_s) begin
            m_d.low_cnt = '0;
        end else if (m_q.low_cnt != LOW_SAT) begin
            m_d.low_cnt = m_q.low_cnt + 1'b1;
        end
        if (!sclk_s && m_q.low_cnt == LOW_TRIP) begin
            m_d.loss  = 1'b1;
            m_d.edges = '0;
            m_d.ok    = 1'b0;
        end else if (rise && m_q.edges != EDGE_MAX) begin
            m_d.edges = m_q.edges + 1'b1;
            m_d.ok    = (m_q.edges + 1'b1) == EDGE_MAX;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign rise_o = rise;
    assign loss_o = m_q.loss;
    assign ok_o   = m_q.ok;

    assert_loss_clears_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
        loss_o |-> !ok_o);

    assert_ok_after_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok_o) |-> $past(rise_o));

endmodule

// File: rtl/sal_parser.sv
module sal_parser
    import sal_pkg::*;
#(
    parameter int SEG_W         = 16,
    parameter int SEGS_PER_ADDR = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bit_stb,
    input  logic                             bit_val,
    input  logic                             clk_ok,
    input  logic                             loss,
    input  logic                             nrdy,
    input  logic                             lkp_busy,
    output logic                             seg_vld,
    output logic [SEG_W-1:0]                 seg_data,
    output logic                             seg_src,
    output logic [$clog2(SEGS_PER_ADDR)-1:0] seg_idx,
    output logic                             frame_err,
    output logic                             abort_o
);

    localparam int BPS    = SEG_W / 8;
    localparam int BC_W   = (BPS > 1) ? $clog2(BPS) : 1;
    localparam int NSEG   = 2 * SEGS_PER_ADDR;
    localparam int SC_W   = $clog2(NSEG);
    localparam int IDX_W  = $clog2(SEGS_PER_ADDR);
    localparam logic [BC_W-1:0] BYTE_LAST = BC_W'(BPS - 1);
    localparam logic [SC_W-1:0] SEG_LAST  = SC_W'(NSEG - 1);
    localparam logic [SC_W-1:0] SEGS_C    = SC_W'(SEGS_PER_ADDR);

    typedef struct packed {
        pstate_e          st;
        logic [7:0]       win;
        logic [2:0]       bitc;
        logic [BC_W-1:0]  bytec;
        logic [7:0]       sh;
        logic [SEG_W-1:0] sbuf;
        logic [SC_W-1:0]  segc;
        logic             vld;
        logic [SEG_W-1:0] data;
        logic             src;
        logic [IDX_W-1:0] idx;
        logic             err;
    } preg_t;

    preg_t p_d, p_q;
    logic [7:0] sh_next;
    logic [7:0] win_next;
    logic       is_src;

    assign sh_next  = {bit_val, p_q.sh[7:1]};
    assign win_next = {p_q.win[6:0], bit_val};
    assign is_src   = p_q.segc >= SEGS_C;

    always_comb begin
        p_d     = p_q;
        p_d.vld = 1'b0;
        p_d.err = 1'b0;
        unique case (p_q.st)
            PS_IDLE: begin
                if (clk_ok && !nrdy) begin
                    p_d.st  = PS_HUNT;
                    p_d.win = '0;
                end
            end
            PS_HUNT: begin
                if (nrdy) begin
                    p_d.st = PS_DRAIN;
                end else if (loss) begin
                    p_d.st = PS_IDLE;
                end else if (bit_stb) begin
                    p_d.win = win_next;
                    if (win_next == SFD_WINDOW) begin
                        p_d.st    = PS_ADDR;
                        p_d.bitc  = '0;
                        p_d.bytec = '0;
                        p_d.segc  = '0;
                        p_d.sh    = '0;
                        p_d.sbuf  = '0;
                    end
                end
            end
            PS_ADDR: begin
                if (nrdy) begin
                    p_d.st = PS_DRAIN;
                end else if (loss) begin
                    p_d.err = 1'b1;
                    p_d.st  = PS_IDLE;
                end else if (bit_stb) begin
                    p_d.sh = sh_next;
                    if (p_q.bitc == 3'd7) begin
                        p_d.bitc = '0;
                        p_d.sbuf = {p_q.sbuf[SEG_W-9:0], sh_next};
                        if (p_q.bytec == BYTE_LAST) begin
                            p_d.bytec = '0;
                            p_d.vld   = 1'b1;
                            p_d.data  = {p_q.sbuf[SEG_W-9:0], sh_next};
                            p_d.src   = is_src;
                            p_d.idx   = IDX_W'(is_src ? (p_q.segc - SEGS_C) : p_q.segc);
                            if (p_q.segc == SEG_LAST) begin
                                p_d.st = PS_DONE;
                            end else begin
                                p_d.segc = p_q.segc + 1'b1;
                            end
                        end else begin
                            p_d.bytec = p_q.bytec + 1'b1;
                        end
                    end else begin
                        p_d.bitc = p_q.bitc + 1'b1;
                    end
                end
            end
            PS_DONE: begin
                if (nrdy) begin
                    p_d.st = PS_DRAIN;
                end else if (loss) begin
                    p_d.st = PS_IDLE;
                end
            end
            PS_DRAIN: begin
                if (!lkp_busy) begin
                    p_d.st = PS_IDLE;
                end
            end
            default: p_d.st = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q    <= '0;
            p_q.st <= PS_IDLE;
        end else begin
            p_q <= p_d;
        end
    end

    assign seg_vld   = p_q.vld;
    assign seg_data  = p_q.data;
    assign seg_src   = p_q.src;
    assign seg_idx   = p_q.idx;
    assign frame_err = p_q.err;
    assign abort_o   = (p_q.st == PS_DRAIN);

    assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seg_vld |-> (seg_idx < IDX_W'(SEGS_PER_ADDR)));

    assert_seg_needs_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seg_vld |-> $past(clk_ok));

    assert_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    assert_abort_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_o && lkp_busy) |=> abort_o);

    assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> !seg_vld);

endmodule

// File: rtl/ser_addr_extract.sv
module ser_addr_extract #(
    parameter int SYNC_STAGES   = 2,
    parameter int LOC_LIMIT     = 16,
    parameter int QUAL_EDGES    = 4,
    parameter int SEG_W         = 16,
    parameter int SEGS_PER_ADDR = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ser_clk,
    input  logic                             ser_dat,
    input  logic                             net_rdy_n,
    input  logic                             lkp_busy,
    output logic                             seg_vld,
    output logic [SEG_W-1:0]                 seg_data,
    output logic                             seg_src,
    output logic [$clog2(SEGS_PER_ADDR)-1:0] seg_idx,
    output logic                             frame_err,
    output logic                             abort_o,
    output logic                             clk_ok
);

    logic [2:0] raw_in;
    logic [2:0] syn_out;
    logic       bit_stb;
    logic       loss;

    assign raw_in = {net_rdy_n, ser_dat, ser_clk};

    sal_sync #(
        .STAGES  (SYNC_STAGES),
        .W       (3),
        .RST_VAL (3'b100)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn_out)
    );

    sal_clk_mon #(
        .LOC_LIMIT  (LOC_LIMIT),
        .QUAL_EDGES (QUAL_EDGES)
    ) mon_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (syn_out[0]),
        .rise_o (bit_stb),
        .loss_o (loss),
        .ok_o   (clk_ok)
    );

    sal_parser #(
        .SEG_W         (SEG_W),
        .SEGS_PER_ADDR (SEGS_PER_ADDR)
    ) prs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb   (bit_stb),
        .bit_val   (syn_out[1]),
        .clk_ok    (clk_ok),
        .loss      (loss),
        .nrdy      (syn_out[2]),
        .lkp_busy  (lkp_busy),
        .seg_vld   (seg_vld),
        .seg_data  (seg_data),
        .seg_src   (seg_src),
        .seg_idx   (seg_idx),
        .frame_err (frame_err),
        .abort_o   (abort_o)
    );

endmodule

// File: tb/ser_addr_extract_tb_top.sv
module ser_addr_extract_tb_top;

    localparam int HALF = 3;

    typedef struct packed {
        logic [47:0] da;
        logic [47:0] sa;
        logic [7:0]  pre;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{da: 48'h0123_4567_89AB, sa: 48'hFEDC_BA98_7654, pre: 8'd7},
        '{da: 48'hFFFF_FFFF_FFFF, sa: 48'h0000_0000_0001, pre: 8'd2},
        '{da: 48'hD5D5_D5D5_D5D5, sa: 48'h5555_5555_5555, pre: 8'd3},
        '{da: 48'h0180_C200_0001, sa: 48'hA1B2_C3D4_E5F6, pre: 8'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        net_rdy_n = 1'b0;
    logic        lkp_busy = 1'b0;
    logic        seg_vld;
    logic [15:0] seg_data;
    logic        seg_src;
    logic [1:0]  seg_idx;
    logic        frame_err;
    logic        abort_o;
    logic        clk_ok;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [15:0] cap_data [256];
    logic [2:0]  cap_tag  [256];
    int cap_n = 0;
    int err_n = 0;

    always #2.5 clk = ~clk;

    ser_addr_extract dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_dat   (ser_dat),
        .net_rdy_n (net_rdy_n),
        .lkp_busy  (lkp_busy),
        .seg_vld   (seg_vld),
        .seg_data  (seg_data),
        .seg_src   (seg_src),
        .seg_idx   (seg_idx),
        .frame_err (frame_err),
        .abort_o   (abort_o),
        .clk_ok    (clk_ok)
    );

    always @(negedge clk) begin
        if (seg_vld) begin
            cap_data[cap_n[7:0]] = seg_data;
            cap_tag[cap_n[7:0]]  = {seg_src, seg_idx};
            cap_n = cap_n + 1;
        end
        if (frame_err) err_n = err_n + 1;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        ser_dat = b;
        ser_clk = 1'b0;
        repeat (HALF) @(negedge clk);
        ser_clk = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
    endtask

    task automatic send_addr(input logic [47:0] a, input int nbytes);
        for (int k = 0; k < nbytes; k++) send_byte(a[47-8*k -: 8]);
    endtask

    task automatic gap(input int n);
        ser_clk = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_head(input int pre);
        for (int k = 0; k < pre; k++) send_byte(8'h55);
        send_byte(8'hD5);
    endtask

    task automatic send_frame(input vec_t v);
        send_head(int'(v.pre));
        send_addr(v.da, 6);
        send_addr(v.sa, 6);
        send_byte(8'h55);
        send_byte(8'hD5);
        send_byte(8'hD5);
        send_byte(8'h55);
    endtask

    task automatic chk_frame(input vec_t v, input int base, input string req);
        logic [47:0] a;
        logic [15:0] ew;
        check(cap_n - base == 6, req, cap_n - base, 6);
        for (int j = 0; j < 6; j++) begin
            a  = (j < 3) ? v.da : v.sa;
            ew = a[47-16*(j%3) -: 16];
            check(cap_data[(base+j)%256] == ew, {req, " R5 data"}, cap_data[(base+j)%256], ew);
            check(cap_tag[(base+j)%256] == {j >= 3, 2'(j%3)}, {req, " R4 tag"},
                  cap_tag[(base+j)%256], {j >= 3, 2'(j%3)});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        int ebase;
        repeat (4) @(negedge clk);
        // R1: during reset
        check({seg_vld, frame_err, abort_o, clk_ok} == 4'b0, "R1 in reset",
              {seg_vld, frame_err, abort_o, clk_ok}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({seg_vld, frame_err, abort_o, clk_ok} == 4'b0, "R1 after release",
              {seg_vld, frame_err, abort_o, clk_ok}, 0);
        gap(30);

        // R2: delimiter as very first bits, lost to clock qualification
        base = cap_n;
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        check(clk_ok == 1'b0, "R2 not yet qualified", clk_ok, 0);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        check(clk_ok == 1'b1, "R2 qualified", clk_ok, 1);
        for (int k = 0; k < 12; k++) send_byte(8'h00);
        gap(40);
        check(cap_n == base, "R2 early delimiter ignored", cap_n - base, 0);

        // table of frames: R3 (preamble lengths), R4, R5, R6 (delimiter in payload), R8
        for (int t = 0; t < 4; t++) begin
            base  = cap_n;
            ebase = err_n;
            send_frame(VECS[t]);
            gap(40);
            chk_frame(VECS[t], base, "R3/R6 table frame");
            check(err_n == ebase, "R8 end of frame no error", err_n - ebase, 0);
            check(clk_ok == 1'b0, "R8 carrier gone", clk_ok, 0);
        end

        // R9: not ready
        net_rdy_n = 1'b1;
        base = cap_n;
        send_frame(VECS[0]);
        gap(40);
        check(cap_n == base, "R9 no parse while not ready", cap_n - base, 0);
        check(abort_o == 1'b0, "R9 no abort from idle", abort_o, 0);
        net_rdy_n = 1'b0;
        gap(10);

        // R7: loss of carrier in the middle of the destination address
        base  = cap_n;
        ebase = err_n;
        send_head(3);
        send_addr(VECS[0].da, 4);
        gap(40);
        check(cap_n - base == 2, "R7 partial segments", cap_n - base, 2);
        check(err_n - ebase == 1, "R7 single error pulse", err_n - ebase, 1);
        check(clk_ok == 1'b0, "R7 clock dropped", clk_ok, 0);

        // R12: next frame clean
        base = cap_n;
        send_frame(VECS[1]);
        gap(40);
        chk_frame(VECS[1], base, "R12 after error");

        // R10: ready withdrawn mid-frame while lookup busy
        lkp_busy = 1'b1;
        base = cap_n;
        send_head(3);
        send_addr(VECS[3].da, 4);
        repeat (2) @(negedge clk);
        check(cap_n - base == 2, "R10 segments before withdraw", cap_n - base, 2);
        net_rdy_n = 1'b1;
        send_addr(VECS[3].sa, 6);
        send_addr(VECS[3].da, 2);
        check(abort_o == 1'b1, "R10 abort held while busy", abort_o, 1);
        check(cap_n - base == 2, "R10 no segments after withdraw", cap_n - base, 2);
        lkp_busy = 1'b0;
        repeat (3) @(negedge clk);
        check(abort_o == 1'b0, "R10 abort released", abort_o, 0);
        gap(40);
        net_rdy_n = 1'b0;
        gap(10);
        base = cap_n;
        send_frame(VECS[2]);
        gap(40);
        chk_frame(VECS[2], base, "R10 frame after abort");

        // R11: reset mid-frame
        base = cap_n;
        send_head(2);
        send_addr(VECS[0].da, 3);
        ser_clk = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check({seg_vld, frame_err, abort_o, clk_ok} == 4'b0, "R11 reset outputs",
              {seg_vld, frame_err, abort_o, clk_ok}, 0);
        rst_n = 1'b1;
        gap(30);
        base = cap_n;
        send_frame(VECS[3]);
        gap(40);
        chk_frame(VECS[3], base, "R11 frame after reset");

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule